// File: doc/BRIEF.md
# PHY Boot and Firmware Load Sequencer

This block brings a high-speed serial PHY out of reset. A single start strobe runs a fixed sequence. It asserts the lane and PHY resets and parks the secondary-protocol transmit lanes disabled and in reset. It then applies the power and boot configuration and waits out a settle window. After that it releases the PHY reset and then the lane reset. Last, it pulses the PHY configuration clock in bursts until the PHY reports that its internal memory is initialised. The boot mode is sampled together with the start strobe.

In RAM boot, the sequencer next writes two fixed override registers through a request/acknowledge register-write port. It then streams firmware entries, each an address/data pair, from a ready/valid input into the same port until an entry marked last has been written. It then raises the configuration clock, sets the load-complete signal, lowers the clock, and polls again in shorter bursts before it reports done. In ROM boot the firmware phase is skipped. Each polling loop has a burst-count watchdog that ends the sequence with an error flag, so the sequencer never hangs.

Top module: `phy_boot_seq`

## Requirements
- R1: After reset: done, timeoutErr, wrReq, fwReady, cfgClk, phyReset, laneReset and loadDone are all 0, and testPowerDown is 1.
- R2: A start strobe in idle, done or error state asserts phyReset, laneReset and every secTxDisable/secTxReset bit. The following cycle sets anaPwrEn=1, testPowerDown=0 and loadDone=0, and sets memBypass to the mode sampled with the strobe (romBoot=1 gives memBypass=1, romBoot=0 gives memBypass=0).
- R3: phyReset falls no earlier than SETTLE_CYC cycles after the configuration is applied, and laneReset falls exactly one cycle after phyReset.
- R4: After laneReset is released, cfgClk runs in bursts of 10 rising edges. initDone is sampled only after a whole burst, with cfgClk low, so the sequence continues after 10*ceil(k/10) rising edges when the PHY needs k edges. cfgClk stays low while phyReset is high.
- R5: In RAM boot the first write is address 0x31C5 with data 0x8000 and the second is address 0x32C5 with data 0x8000. The firmware entries follow in arrival order. A request holds its address and data stable until wrAck.
- R6: fwReady is high only during the firmware phase and only while no write is pending. The entry with fwLast=1 is the final one written.
- R7: loadDone rises only after the last firmware write is acknowledged, and only while cfgClk is high. cfgClk is lowered afterwards.
- R8: After loadDone, cfgClk runs in bursts of 8 rising edges until initDone is seen high after a burst. done then rises.
- R9: In ROM boot no register write is issued, fwReady stays 0 and loadDone stays 0. done rises after the first polling loop.
- R10: If initDone is still low after POLL_LIMIT bursts in either loop, timeoutErr rises, done stays 0 and cfgClk stops toggling.
- R11: A start strobe is ignored while a sequence is in progress, so the settle window and the rest of the run are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a bring-up sequence |
| romBoot | input | 1 | Boot mode, sampled with startPulse: 1 ROM, 0 RAM |
| fwValid | input | 1 | Firmware entry valid |
| fwReady | output | 1 | Firmware entry accepted |
| fwAddr | input | ADDR_W | Firmware entry register address |
| fwData | input | DATA_W | Firmware entry data |
| fwLast | input | 1 | Marks the final firmware entry |
| initDone | input | 1 | PHY memory initialisation complete |
| wrReq | output | 1 | Register write request, held until acknowledged |
| wrAddr | output | ADDR_W | Register write address |
| wrData | output | DATA_W | Register write data |
| wrAck | input | 1 | Register write acknowledge |
| phyReset | output | 1 | PHY reset, active high |
| laneReset | output | 1 | Lane reset, active high |
| secTxDisable | output | SEC_LANES | Secondary-protocol transmit lane disables |
| secTxReset | output | SEC_LANES | Secondary-protocol transmit lane resets |
| anaPwrEn | output | 1 | Analog power enable |
| testPowerDown | output | 1 | Test power-down control |
| memBypass | output | 1 | Bypass internal memory (ROM boot) |
| loadDone | output | 1 | Firmware load complete |
| cfgClk | output | 1 | PHY configuration clock |
| done | output | 1 | Sequence completed |
| timeoutErr | output | 1 | A polling loop exhausted its watchdog |

## Verification
The hardest situation to reach is a timeout in the second polling loop. It needs a full firmware stream to finish first, and then the PHY must drop and withhold its init-done status after load-complete rises. The bench's PHY model therefore counts configuration-clock rising edges separately before and after load-complete, against two independently set thresholds. A requirement for an unreachable count sends either loop into its watchdog. A stray start strobe is injected in the middle of the settle window, and the exact hold time of the PHY reset shows whether it was ignored.

// File: rtl/phy_boot_pkg.sv
package phy_boot_pkg;

  typedef enum logic [1:0] {
    WSRC_OVR_A  = 2'd0,
    WSRC_OVR_B  = 2'd1,
    WSRC_STREAM = 2'd2
  } wrSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   holdAll;     // assert resets and park secondary lanes
    logic   applyCfg;    // power up and boot mode
    logic   bypassVal;   // memory bypass value applied with applyCfg
    logic   settleLoad;  // start settle window
    logic   relPhy;      // release PHY reset
    logic   relLane;     // release lane reset
    logic   burstLoad;   // start a configuration clock burst
    logic   burstLong;   // 1: long burst, 0: short burst
    logic   wdClear;     // restart polling watchdog
    logic   wdStep;      // count one more burst
    logic   wrLaunch;    // issue a register write
    wrSrc_e wrSel;       // source of that write
    logic   clkRaise;    // drive configuration clock high
    logic   ldSet;       // set load-complete
    logic   clkFall;     // drive configuration clock low
  } ctlStrobe_t;

  typedef struct packed {
    logic settleDone;
    logic burstDone;
    logic wdExpired;
    logic wrIdle;
  } dpStatus_t;

  localparam logic [15:0] OVR_ADDR_A = 16'h31C5;
  localparam logic [15:0] OVR_ADDR_B = 16'h32C5;
  localparam logic [15:0] OVR_DATA   = 16'h8000;

endpackage

// File: rtl/phy_boot_ctrl.sv
module phy_boot_ctrl
  import phy_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       romBoot,
  input  logic       fwValid,
  input  logic       fwLast,
  input  logic       initDone,
  input  dpStatus_t  st,
  output ctlStrobe_t stb,
  output logic       fwReady,
  output logic       done,
  output logic       timeoutErr
);

  typedef enum logic [4:0] {
    S_IDLE, S_ASSERT, S_CONFIG, S_SETTLE, S_REL_PHY, S_REL_LANE,
    S_POLL1, S_CHK1, S_OVR_A, S_OVR_A_W, S_OVR_B, S_OVR_B_W,
    S_FW, S_FW_W, S_LD_RAISE, S_LD_SET, S_LD_FALL, S_KICK2,
    S_POLL2, S_CHK2, S_DONE, S_FAIL
  } state_e;

  state_e state, nxt;
  logic   romQ;
  logic   lastQ;
  logic   canStart;

  assign canStart = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      romQ  <= 1'b0;
      lastQ <= 1'b0;
    end else begin
      state <= nxt;
      if (canStart && startPulse) romQ <= romBoot;
      if (state == S_FW && fwValid) lastQ <= fwLast;
    end
  end

  always_comb begin
    stb     = '0;
    nxt     = state;
    fwReady = 1'b0;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: if (startPulse) nxt = S_ASSERT;
      S_ASSERT: begin
        stb.holdAll = 1'b1;
        nxt = S_CONFIG;
      end
      S_CONFIG: begin
        stb.applyCfg   = 1'b1;
        stb.bypassVal  = romQ;
        stb.settleLoad = 1'b1;
        nxt = S_SETTLE;
      end
      S_SETTLE: if (st.settleDone) nxt = S_REL_PHY;
      S_REL_PHY: begin
        stb.relPhy = 1'b1;
        nxt = S_REL_LANE;
      end
      S_REL_LANE: begin
        stb.relLane   = 1'b1;
        stb.burstLoad = 1'b1;
        stb.burstLong = 1'b1;
        stb.wdClear   = 1'b1;
        nxt = S_POLL1;
      end
      S_POLL1: if (st.burstDone) nxt = S_CHK1;
      S_CHK1: begin
        if (initDone)          nxt = romQ ? S_DONE : S_OVR_A;
        else if (st.wdExpired) nxt = S_FAIL;
        else begin
          stb.burstLoad = 1'b1;
          stb.burstLong = 1'b1;
          stb.wdStep    = 1'b1;
          nxt = S_POLL1;
        end
      end
      S_OVR_A: begin
        stb.wrLaunch = 1'b1;
        stb.wrSel    = WSRC_OVR_A;
        nxt = S_OVR_A_W;
      end
      S_OVR_A_W: if (st.wrIdle) nxt = S_OVR_B;
      S_OVR_B: begin
        stb.wrLaunch = 1'b1;
        stb.wrSel    = WSRC_OVR_B;
        nxt = S_OVR_B_W;
      end
      S_OVR_B_W: if (st.wrIdle) nxt = S_FW;
      S_FW: begin
        fwReady = 1'b1;
        if (fwValid) begin
          stb.wrLaunch = 1'b1;
          stb.wrSel    = WSRC_STREAM;
          nxt = S_FW_W;
        end
      end
      S_FW_W: if (st.wrIdle) nxt = lastQ ? S_LD_RAISE : S_FW;
      S_LD_RAISE: begin
        stb.clkRaise = 1'b1;
        nxt = S_LD_SET;
      end
      S_LD_SET: begin
        stb.ldSet = 1'b1;
        nxt = S_LD_FALL;
      end
      S_LD_FALL: begin
        stb.clkFall = 1'b1;
        nxt = S_KICK2;
      end
      S_KICK2: begin
        stb.burstLoad = 1'b1;
        stb.wdClear   = 1'b1;
        nxt = S_POLL2;
      end
      S_POLL2: if (st.burstDone) nxt = S_CHK2;
      S_CHK2: begin
        if (initDone)          nxt = S_DONE;
        else if (st.wdExpired) nxt = S_FAIL;
        else begin
          stb.burstLoad = 1'b1;
          stb.wdStep    = 1'b1;
          nxt = S_POLL2;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign done       = (state == S_DONE);
  assign timeoutErr = (state == S_FAIL);

endmodule

// File: rtl/phy_boot_dp.sv
module phy_boot_dp
  import phy_boot_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SEC_LANES   = 4,
  parameter int SETTLE_CYC  = 2000,
  parameter int POLL_LIMIT  = 64,
  parameter int LONG_BURST  = 10,
  parameter int SHORT_BURST = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           stb,
  input  logic [ADDR_W-1:0]    fwAddr,
  input  logic [DATA_W-1:0]    fwData,
  input  logic                 wrAck,
  output dpStatus_t            st,
  output logic                 wrReq,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic                 phyReset,
  output logic                 laneReset,
  output logic [SEC_LANES-1:0] secTxDisable,
  output logic [SEC_LANES-1:0] secTxReset,
  output logic                 anaPwrEn,
  output logic                 testPowerDown,
  output logic                 memBypass,
  output logic                 loadDone,
  output logic                 cfgClk
);

  localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
  localparam int PH_W     = $clog2(2 * LONG_BURST + 1);
  localparam int WD_W     = $clog2(POLL_LIMIT + 1);

  logic [SETTLE_W-1:0] settleCnt;
  logic [PH_W-1:0]     phaseCnt;
  logic [WD_W-1:0]     wdCnt;

  // reset, power and boot configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyReset      <= 1'b0;
      laneReset     <= 1'b0;
      anaPwrEn      <= 1'b0;
      testPowerDown <= 1'b1;
      memBypass     <= 1'b0;
      loadDone      <= 1'b0;
    end else begin
      if (stb.holdAll) begin
        phyReset  <= 1'b1;
        laneReset <= 1'b1;
      end
      if (stb.relPhy)  phyReset  <= 1'b0;
      if (stb.relLane) laneReset <= 1'b0;
      if (stb.applyCfg) begin
        anaPwrEn      <= 1'b1;
        testPowerDown <= 1'b0;
        loadDone      <= 1'b0;
        memBypass     <= stb.bypassVal;
      end
      if (stb.ldSet) loadDone <= 1'b1;
    end
  end

  // secondary-protocol transmit lanes, parked per lane
  for (genvar g = 0; g < SEC_LANES; g++) begin : g_sec
    logic disQ, rstQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        disQ <= 1'b0;
        rstQ <= 1'b0;
      end else if (stb.holdAll) begin
        disQ <= 1'b1;
        rstQ <= 1'b1;
      end
    end
    assign secTxDisable[g] = disQ;
    assign secTxReset[g]   = rstQ;
  end

  // settle window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                settleCnt <= '0;
    else if (stb.settleLoad)  settleCnt <= SETTLE_W'(SETTLE_CYC);
    else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end

  // configuration clock: bursts plus explicit raise/fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      cfgClk   <= 1'b0;
    end else if (stb.burstLoad) begin
      phaseCnt <= stb.burstLong ? PH_W'(2 * LONG_BURST) : PH_W'(2 * SHORT_BURST);
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
      cfgClk   <= ~cfgClk;
    end else if (stb.clkRaise) begin
      cfgClk <= 1'b1;
    end else if (stb.clkFall) begin
      cfgClk <= 1'b0;
    end
  end

  // polling watchdog, counts bursts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wdCnt <= '0;
    else if (stb.wdClear) wdCnt <= '0;
    else if (stb.wdStep)  wdCnt <= wdCnt + 1'b1;
  end

  // register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReq  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else if (stb.wrLaunch) begin
      wrReq <= 1'b1;
      unique case (stb.wrSel)
        WSRC_OVR_A: begin
          wrAddr <= ADDR_W'(OVR_ADDR_A);
          wrData <= DATA_W'(OVR_DATA);
        end
        WSRC_OVR_B: begin
          wrAddr <= ADDR_W'(OVR_ADDR_B);
          wrData <= DATA_W'(OVR_DATA);
        end
        default: begin
          wrAddr <= fwAddr;
          wrData <= fwData;
        end
      endcase
    end else if (wrReq && wrAck) begin
      wrReq <= 1'b0;
    end
  end

  assign st.settleDone = (settleCnt == '0);
  assign st.burstDone  = (phaseCnt == '0);
  assign st.wdExpired  = (wdCnt == WD_W'(POLL_LIMIT - 1));
  assign st.wrIdle     = !wrReq;

endmodule

// File: rtl/phy_boot_seq.sv
module phy_boot_seq
  import phy_boot_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SEC_LANES  = 4,
  parameter int SETTLE_CYC = 2000,
  parameter int POLL_LIMIT = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic                 romBoot,
  input  logic                 fwValid,
  output logic                 fwReady,
  input  logic [ADDR_W-1:0]    fwAddr,
  input  logic [DATA_W-1:0]    fwData,
  input  logic                 fwLast,
  input  logic                 initDone,
  output logic                 wrReq,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [DATA_W-1:0]    wrData,
  input  logic                 wrAck,
  output logic                 phyReset,
  output logic                 laneReset,
  output logic [SEC_LANES-1:0] secTxDisable,
  output logic [SEC_LANES-1:0] secTxReset,
  output logic                 anaPwrEn,
  output logic                 testPowerDown,
  output logic                 memBypass,
  output logic                 loadDone,
  output logic                 cfgClk,
  output logic                 done,
  output logic                 timeoutErr
);

  ctlStrobe_t stb;
  dpStatus_t  st;

  phy_boot_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .romBoot    (romBoot),
    .fwValid    (fwValid),
    .fwLast     (fwLast),
    .initDone   (initDone),
    .st         (st),
    .stb        (stb),
    .fwReady    (fwReady),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  phy_boot_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SEC_LANES  (SEC_LANES),
    .SETTLE_CYC (SETTLE_CYC),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .fwAddr        (fwAddr),
    .fwData        (fwData),
    .wrAck         (wrAck),
    .st            (st),
    .wrReq         (wrReq),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .phyReset      (phyReset),
    .laneReset     (laneReset),
    .secTxDisable  (secTxDisable),
    .secTxReset    (secTxReset),
    .anaPwrEn      (anaPwrEn),
    .testPowerDown (testPowerDown),
    .memBypass     (memBypass),
    .loadDone      (loadDone),
    .cfgClk        (cfgClk)
  );

endmodule

// File: rtl/phy_boot_chk.sv
module phy_boot_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              fwReady,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrAck,
  input logic              phyReset,
  input logic              laneReset,
  input logic              testPowerDown,
  input logic              memBypass,
  input logic              loadDone,
  input logic              cfgClk,
  input logic              done,
  input logic              timeoutErr
);

  AST_LANE_AFTER_PHY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(laneReset) |-> !phyReset && !$past(phyReset)); // R3

  AST_CLK_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!rstN)
    phyReset |-> !cfgClk); // R4

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> wrReq && $stable(wrAddr) && $stable(wrData)); // R5

  AST_READY_NO_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    fwReady |-> !wrReq); // R6

  AST_LD_UNDER_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> cfgClk); // R7

  AST_ROM_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (memBypass && !testPowerDown) |-> !fwReady && !wrReq); // R9

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeoutErr)); // R10

  AST_ERR_CLK_STOP: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !cfgClk); // R10

endmodule

bind phy_boot_seq phy_boot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_phy_boot_seq.sv
module tb_phy_boot_seq;

  localparam int AW     = 16;
  localparam int DW     = 16;
  localparam int NL     = 4;
  localparam int SETTLE = 300;
  localparam int PLIM   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          romBoot = 1'b0;
  logic          fwValid = 1'b0;
  logic          fwReady;
  logic [AW-1:0] fwAddr = '0;
  logic [DW-1:0] fwData = '0;
  logic          fwLast = 1'b0;
  logic          initDone;
  logic          wrReq;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          wrAck = 1'b0;
  logic          phyReset, laneReset, anaPwrEn, testPowerDown, memBypass;
  logic          loadDone, cfgClk, done, timeoutErr;
  logic [NL-1:0] secTxDisable, secTxReset;

  always #5 clk = ~clk;

  phy_boot_seq #(.ADDR_W(AW), .DATA_W(DW), .SEC_LANES(NL),
                 .SETTLE_CYC(SETTLE), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .romBoot(romBoot),
    .fwValid(fwValid), .fwReady(fwReady), .fwAddr(fwAddr), .fwData(fwData),
    .fwLast(fwLast), .initDone(initDone), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .wrAck(wrAck), .phyReset(phyReset), .laneReset(laneReset),
    .secTxDisable(secTxDisable), .secTxReset(secTxReset), .anaPwrEn(anaPwrEn),
    .testPowerDown(testPowerDown), .memBypass(memBypass), .loadDone(loadDone),
    .cfgClk(cfgClk), .done(done), .timeoutErr(timeoutErr));

  int checks = 0;
  int errors = 0;

  // monitor state
  int cyc = 0, holdCnt = 0, phyFallCyc = 0, laneGap = -1;
  int riseTotal = 0, riseRel = 0, riseLd = 0, risesAtFirstWr = -1;
  int wrN = 0, fwReadyViol = 0, fwReadySeen = 0, clkInRst = 0;
  int ldClkOk = -1, wrAtLd = -1;
  int need1 = 100000, need2 = 100000;
  logic prevPhy = 1'b0, prevLane = 1'b0, prevClk = 1'b0, prevLd = 1'b0;
  logic [AW-1:0] logA [64];
  logic [DW-1:0] logD [64];
  int ackCnt = 0;

  // PHY model: init-done after enough configuration clock edges
  assign initDone = loadDone ? (riseLd >= need2) : (!laneReset && (riseRel >= need1));

  // write acknowledge after a short delay
  always @(posedge clk) begin
    if (wrReq && !wrAck) begin
      if (ackCnt == 2) begin wrAck <= 1'b1; ackCnt <= 0; end
      else ackCnt <= ackCnt + 1;
    end else begin
      wrAck  <= 1'b0;
      ackCnt <= 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (phyReset && anaPwrEn && !testPowerDown) holdCnt++;
    if (prevPhy && !phyReset) phyFallCyc = cyc;
    if (prevLane && !laneReset) laneGap = cyc - phyFallCyc;
    if (cfgClk && !prevClk) begin
      riseTotal++;
      if (loadDone) riseLd++;
      else if (!laneReset) riseRel++;
    end
    if (cfgClk && phyReset) clkInRst++;
    if (fwReady) fwReadySeen++;
    if (fwReady && wrReq) fwReadyViol++;
    if (wrReq && wrAck) begin
      if (wrN == 0) risesAtFirstWr = riseTotal;
      if (wrN < 64) begin logA[wrN] = wrAddr; logD[wrN] = wrData; end
      wrN++;
    end
    if (loadDone && !prevLd) begin ldClkOk = int'(cfgClk); wrAtLd = wrN; end
    prevPhy = phyReset; prevLane = laneReset; prevClk = cfgClk; prevLd = loadDone;
  end

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkGe(input string req, input string what, input longint act, input longint lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  function automatic logic [AW-1:0] eAddr(input int i, input int seed);
    return AW'(16'h0400 + i * 5 + seed);
  endfunction

  function automatic logic [DW-1:0] eData(input int i, input int seed);
    return DW'((i * 16'h0111) ^ (seed * 3) ^ 16'hA5A5);
  endfunction

  function automatic int roundUp(input int v, input int step);
    return ((v + step - 1) / step) * step;
  endfunction

  task automatic startSeq(input logic rom);
    romBoot = rom; startPulse = 1'b1;
    holdCnt = 0; laneGap = -1; riseTotal = 0; riseRel = 0; riseLd = 0;
    risesAtFirstWr = -1; wrN = 0; fwReadyViol = 0; fwReadySeen = 0;
    clkInRst = 0; ldClkOk = -1; wrAtLd = -1;
    @(negedge clk);
    startPulse = 1'b0;
    romBoot = ~rom;  // must not matter after sampling (R2)
  endtask

  task automatic pushAll(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      fwValid = 1'b1; fwAddr = eAddr(i, seed); fwData = eData(i, seed);
      fwLast = (i == n - 1);
      while (!fwReady) @(negedge clk);
      @(negedge clk);
      fwValid = 1'b0; fwLast = 1'b0;
    end
  endtask

  task automatic waitEnd();
    for (int k = 0; k < 20000 && !(done || timeoutErr); k++) @(negedge clk);
  endtask

  task automatic checkCfg(input string tag, input logic rom);
    chkEq("R2", {tag, " anaPwrEn"}, anaPwrEn, 1);
    chkEq("R2", {tag, " testPowerDown"}, testPowerDown, 0);
    chkEq("R2", {tag, " memBypass"}, memBypass, rom);
    chkEq("R2", {tag, " secTxDisable"}, secTxDisable, {NL{1'b1}});
    chkEq("R2", {tag, " secTxReset"}, secTxReset, {NL{1'b1}});
    chkEq("R4", {tag, " cfgClk during reset"}, clkInRst, 0);
  endtask

  task automatic testReset();
    chkEq("R1", "done", done, 0);
    chkEq("R1", "timeoutErr", timeoutErr, 0);
    chkEq("R1", "wrReq", wrReq, 0);
    chkEq("R1", "fwReady", fwReady, 0);
    chkEq("R1", "cfgClk", cfgClk, 0);
    chkEq("R1", "phyReset", phyReset, 0);
    chkEq("R1", "laneReset", laneReset, 0);
    chkEq("R1", "loadDone", loadDone, 0);
    chkEq("R1", "testPowerDown", testPowerDown, 1);
  endtask

  task automatic testRam(input string tag, input int n, input int seed, input int n1,
                         input int n2, input bit stray, input bit expDone);
    need1 = n1; need2 = n2;
    startSeq(1'b0);
    fork
      pushAll(n, seed);
      begin
        if (stray) begin
          while (holdCnt < 50) @(negedge clk);
          startPulse = 1'b1;
          @(negedge clk);
          startPulse = 1'b0;
        end
      end
    join
    waitEnd();
    checkCfg(tag, 1'b0);
    if (stray) chkEq("R11", {tag, " reset hold with stray start"}, holdCnt, SETTLE + 2);
    chkGe("R3", {tag, " reset hold"}, holdCnt, SETTLE);
    chkEq("R3", {tag, " lane release gap"}, laneGap, 1);
    chkEq("R4", {tag, " rises before first write"}, risesAtFirstWr, roundUp(n1, 10));
    chkEq("R5", {tag, " write count"}, wrN, n + 2);
    chkEq("R5", {tag, " write0 addr"}, logA[0], 16'h31C5);
    chkEq("R5", {tag, " write0 data"}, logD[0], 16'h8000);
    chkEq("R5", {tag, " write1 addr"}, logA[1], 16'h32C5);
    chkEq("R5", {tag, " write1 data"}, logD[1], 16'h8000);
    for (int i = 0; i < n; i++) begin
      chkEq("R5", {tag, " fw addr"}, logA[i + 2], eAddr(i, seed));
      chkEq("R5", {tag, " fw data"}, logD[i + 2], eData(i, seed));
    end
    chkEq("R6", {tag, " ready while pending"}, fwReadyViol, 0);
    chkEq("R6", {tag, " ready cycles after last"}, int'(fwReady), 0);
    chkEq("R7", {tag, " clk high at load-done"}, ldClkOk, 1);
    chkEq("R7", {tag, " writes before load-done"}, wrAtLd, n + 2);
    chkEq("R7", {tag, " loadDone"}, loadDone, 1);
    if (expDone) begin
      chkEq("R8", {tag, " rises after load-done"}, riseLd, roundUp(n2, 8));
      chkEq("R8", {tag, " done"}, done, 1);
      chkEq("R8", {tag, " no error"}, timeoutErr, 0);
    end else begin
      chkEq("R10", {tag, " rises after load-done"}, riseLd, 8 * PLIM);
      chkEq("R10", {tag, " timeoutErr"}, timeoutErr, 1);
      chkEq("R10", {tag, " done low"}, done, 0);
    end
  endtask

  task automatic testRom(input int n1);
    need1 = n1; need2 = 100000;
    startSeq(1'b1);
    waitEnd();
    checkCfg("rom", 1'b1);
    chkEq("R9", "rom done", done, 1);
    chkEq("R9", "rom writes", wrN, 0);
    chkEq("R9", "rom fwReady cycles", fwReadySeen, 0);
    chkEq("R9", "rom loadDone", loadDone, 0);
    chkEq("R4", "rom rises", riseTotal, roundUp(n1, 10));
  endtask

  task automatic testTimeoutFirst();
    need1 = 100000; need2 = 100000;
    startSeq(1'b0);
    waitEnd();
    chkEq("R10", "poll1 timeoutErr", timeoutErr, 1);
    chkEq("R10", "poll1 done low", done, 0);
    chkEq("R10", "poll1 rises", riseTotal, 10 * PLIM);
    repeat (30) @(negedge clk);
    chkEq("R10", "poll1 clock stopped", riseTotal, 10 * PLIM);
    chkEq("R10", "poll1 no stream", fwReadySeen, 0);
  endtask

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRam("ram1", 5, 1, 25, 5, 1'b1, 1'b1);
    testRom(13);
    testTimeoutFirst();
    testRam("ram2", 2, 7, 5, 100000, 1'b0, 1'b0);
    testRam("ram3", 4, 3, 31, 17, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule